// File: doc/BRIEF.md
# Vector integer reduction unit

The unit folds the active elements of one vector operand into a single scalar. The fold is a wrapping sum, a bitwise AND, OR or XOR, or a signed or unsigned minimum or maximum. The accumulator does not start from the identity value of the operation. It starts from element 0 of a second vector, so a reduction can continue a partial result from an earlier one.

A pulse on `start` while the unit is idle captures every operand. The unit then takes one element per clock in ascending index order. Elements whose mask bit is clear are skipped when masking is enabled. The unit then returns a full-width destination vector that holds the result in element 0 and zeros in every other bit. A one-cycle `done` pulse marks the destination as valid. The destination holds its value until the next completion.

The element width can be 8, 16, 32 or 64 bits. An active length greater than the number of elements that fit in the vector is cut down to that number. An operation code outside the eight defined codes does not iterate. It completes at once with an error flag and an all-zero destination.

Top module: `vred_unit`

## Requirements
- R1: `funct6` selects the operation: 0 wrapping sum, 1 AND, 2 OR, 3 XOR, 4 unsigned minimum, 5 signed (two's complement) minimum, 6 unsigned maximum, 7 signed maximum.
- R2: The accumulator starts from the low SEW bits of `seed_vec` (element 0). Higher bits of `seed_vec` have no effect on the result.
- R3: Elements 0 to n-1 of `src_vec` are folded in ascending order, where n is the smaller of `vl` and VLEN/SEW. Elements at index n and above do not affect the result.
- R4: When `all_active` is 0, element i is skipped if bit i of `mask_vec` is 0, and the accumulator keeps its value. When `all_active` is 1, the mask is ignored.
- R5: `ew` encodes the element width as 0=8, 1=16, 2=32 and 3=64 bits. Element i occupies bits [i*SEW +: SEW]. The sum wraps modulo 2^SEW.
- R6: On completion, `dest` holds the result in bits [SEW-1:0] and zero in every other bit.
- R7: When n is 0, or when every element in range is masked off, the result equals the seed element.
- R8: After reset, `busy`, `done` and `err` are 0 and `dest` is 0. For an accepted start with n>0 and a valid operation, `busy` is high for the n cycles after the accepting edge. `done` is then high for exactly one cycle, and `busy` and `done` are never high together. With n=0 or an invalid operation, `done` is high in the cycle right after the accepting edge.
- R9: A `start` pulse while `busy` is high is ignored. `dest` changes only in a cycle where `done` is high and holds its value otherwise.
- R10: A `funct6` value above 7 raises `err` together with `done` and sets `dest` to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, to be released synchronously to `clk` |
| start | input | 1 | Begin a reduction; sampled only while idle |
| funct6 | input | 6 | Operation code |
| ew | input | 2 | Element width code |
| vl | input | VLW | Active element count |
| all_active | input | 1 | 1: ignore the mask; 0: skip elements whose mask bit is 0 |
| src_vec | input | VLEN | Vector whose elements are reduced |
| seed_vec | input | VLEN | Vector whose element 0 seeds the accumulator |
| mask_vec | input | VLEN | One mask bit per element, bit i for element i |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse: `dest` is valid |
| err | output | 1 | Unknown operation code, high together with `done` |
| dest | output | VLEN | Destination vector |

## Verification
On every cycle the assertions check the following:
- `busy` and `done` are never high together.
- An error comes only with `done` and an all-zero destination.
- The destination stays stable between completions, and its bits above the element width are clear.
- A masked-off element leaves the accumulator unchanged.
- A start pulse during iteration changes no captured operand.
- Unsigned maximum never lowers the running value, and unsigned minimum never raises it.
- The element index stays below the clamped length.

Only the bench scenarios can show that each operation produces the correct value. These scenarios cover signed against unsigned ordering on the same bit patterns and the wrap of the sum. They also cover the clamping of an oversized length, a seed with junk above element 0, masking against all-active, and the latency of each completion as a number of cycles.

// File: rtl/vred_pkg.sv
package vred_pkg;

  typedef enum logic [5:0] {
    OP_SUM  = 6'd0,
    OP_AND  = 6'd1,
    OP_OR   = 6'd2,
    OP_XOR  = 6'd3,
    OP_MINU = 6'd4,
    OP_MIN  = 6'd5,
    OP_MAXU = 6'd6,
    OP_MAX  = 6'd7
  } red_op_e;

  localparam int unsigned EL_MAXW = 64;

  // Ones over the low SEW bits for an element width code.
  function automatic logic [EL_MAXW-1:0] ew_mask(input logic [1:0] ew);
    case (ew)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  // Sign extension from the element width up to 64 bits.
  function automatic logic [EL_MAXW-1:0] ew_sext(input logic [EL_MAXW-1:0] v,
                                                 input logic [1:0] ew);
    case (ew)
      2'd0:    return {{56{v[7]}},  v[7:0]};
      2'd1:    return {{48{v[15]}}, v[15:0]};
      2'd2:    return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic op_known(input logic [5:0] f);
    return (f[5:3] == 3'b000);
  endfunction

endpackage

// File: rtl/vred_pick.sv
// Selects element idx_i of the vector at the width given by ew_i,
// zero-extended to 64 bits. One lane array per supported width.
module vred_pick #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned IDXW = $clog2(VLEN/8)
) (
  input  logic [VLEN-1:0] vec_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [1:0]      ew_i,
  output logic [63:0]     elem_o
);

  logic [63:0] cand [4];

  for (genvar k = 0; k < 4; k++) begin : g_ew
    localparam int unsigned W  = 8 << k;
    localparam int unsigned N  = VLEN / W;
    localparam int unsigned LW = $clog2(N);
    logic [W-1:0] lane [N];
    for (genvar j = 0; j < N; j++) begin : g_lane
      assign lane[j] = vec_i[j*W +: W];
    end
    assign cand[k] = 64'(lane[idx_i[LW-1:0]]);
  end

  assign elem_o = cand[ew_i];

endmodule

// File: rtl/vred_fold.sv
// One reduction step: combines the running value with one element.
module vred_fold
  import vred_pkg::*;
(
  input  logic [5:0]  op_i,
  input  logic [1:0]  ew_i,
  input  logic [63:0] acc_i,
  input  logic [63:0] elem_i,
  output logic [63:0] res_o
);

  logic [63:0] wmask, a, b, as, bs, raw;
  logic        ult, slt;

  always_comb begin
    wmask = ew_mask(ew_i);
    a     = acc_i & wmask;
    b     = elem_i & wmask;
    as    = ew_sext(a, ew_i);
    bs    = ew_sext(b, ew_i);
    ult   = (a < b);
    slt   = ($signed(as) < $signed(bs));
    case (op_i)
      OP_SUM:  raw = a + b;
      OP_AND:  raw = a & b;
      OP_OR:   raw = a | b;
      OP_XOR:  raw = a ^ b;
      OP_MINU: raw = ult ? a : b;
      OP_MIN:  raw = slt ? a : b;
      OP_MAXU: raw = ult ? b : a;
      OP_MAX:  raw = slt ? b : a;
      default: raw = a;
    endcase
    res_o = raw & wmask;
  end

endmodule

// File: rtl/vred_seq.sv
// Sequencer: accepts a start while idle, walks the element index,
// flags the cycle in which the reduction completes.
module vred_seq #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned IDXW = $clog2(VLEN/8),
  parameter int unsigned VLW  = $clog2(VLEN/8 + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [VLW-1:0]  len_i,
  input  logic            op_ok_i,
  output logic            accept_o,
  output logic            busy_o,
  output logic [IDXW-1:0] idx_o,
  output logic            fin_o
);

  logic            busy_q, busy_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [VLW-1:0]  len_q, len_d;
  logic            go_run, last;

  always_comb begin
    accept_o = start_i & ~busy_q;
    go_run   = accept_o & op_ok_i & (len_i != '0);
    last     = busy_q & ((VLW'(idx_q) + VLW'(1)) == len_q);
    fin_o    = (accept_o & ~go_run) | last;

    busy_d = busy_q;
    idx_d  = idx_q;
    len_d  = len_q;
    if (go_run) begin
      busy_d = 1'b1;
      idx_d  = '0;
      len_d  = len_i;
    end else if (busy_q) begin
      if (last) busy_d = 1'b0;
      else      idx_d  = idx_q + IDXW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;

  // R3: the visited index never reaches the clamped length
  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (VLW'(idx_q) < len_q));

endmodule

// File: rtl/vred_unit.sv
module vred_unit
  import vred_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned VLW  = $clog2(VLEN/8 + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [5:0]      funct6,
  input  logic [1:0]      ew,
  input  logic [VLW-1:0]  vl,
  input  logic            all_active,
  input  logic [VLEN-1:0] src_vec,
  input  logic [VLEN-1:0] seed_vec,
  input  logic [VLEN-1:0] mask_vec,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [VLEN-1:0] dest
);

  localparam int unsigned NB   = VLEN / 8;
  localparam int unsigned IDXW = $clog2(NB);

  // captured operands (data registers, no reset)
  logic [5:0]      op_q;
  logic [1:0]      ew_q;
  logic            aa_q;
  logic [VLEN-1:0] src_q, mask_q;

  logic [63:0]     acc_q, acc_d;
  logic            done_q, done_d, err_q, err_d;
  logic [VLEN-1:0] dest_q, dest_d;

  logic            accept, fin, step;
  logic [IDXW-1:0] idx;
  logic [VLW-1:0]  cap, len_eff;
  logic [63:0]     elem, fold_res, seed0;
  logic            elem_on, op_ok;

  always_comb begin
    cap     = VLW'(NB >> ew);
    len_eff = (vl > cap) ? cap : vl;
    op_ok   = op_known(funct6);
    seed0   = seed_vec[63:0] & ew_mask(ew);
  end

  vred_seq #(.VLEN(VLEN), .IDXW(IDXW), .VLW(VLW)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .len_i    (len_eff),
    .op_ok_i  (op_ok),
    .accept_o (accept),
    .busy_o   (step),
    .idx_o    (idx),
    .fin_o    (fin)
  );

  vred_pick #(.VLEN(VLEN), .IDXW(IDXW)) pick_i (
    .vec_i  (src_q),
    .idx_i  (idx),
    .ew_i   (ew_q),
    .elem_o (elem)
  );

  vred_fold fold_i (
    .op_i   (op_q),
    .ew_i   (ew_q),
    .acc_i  (acc_q),
    .elem_i (elem),
    .res_o  (fold_res)
  );

  // operand capture with explicit enable
  always_ff @(posedge clk) begin
    if (accept) begin
      op_q   <= funct6;
      ew_q   <= ew;
      aa_q   <= all_active;
      src_q  <= src_vec;
      mask_q <= mask_vec;
    end
  end

  // next state
  always_comb begin
    elem_on = aa_q | mask_q[idx];
    acc_d   = acc_q;
    if (accept)                acc_d = seed0;
    else if (step && elem_on)  acc_d = fold_res;

    done_d = fin;
    err_d  = accept & ~op_ok;
    dest_d = dest_q;
    if (fin) dest_d = err_d ? '0 : VLEN'(acc_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      dest_q <= '0;
    end else begin
      acc_q  <= acc_d;
      done_q <= done_d;
      err_q  <= err_d;
      dest_q <= dest_d;
    end
  end

  assign busy = step;
  assign done = done_q;
  assign err  = err_q;
  assign dest = dest_q;

  // R8: iteration and completion never overlap
  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R10: error only with completion and a cleared destination
  assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && (dest == '0)));

  // R9: destination holds between completions
  assert_dest_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dest));

  // R9: start during iteration leaves the captured operands alone
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(src_q) && $stable(op_q)));

  // R6: nothing above element 0 in the destination
  assert_upper_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((dest & ~VLEN'(ew_mask(ew_q))) == '0));

  // R4: masked-off element leaves the accumulator unchanged
  assert_masked_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !aa_q && !mask_q[idx]) |=> (acc_q == $past(acc_q)));

  // R1: unsigned max never lowers, unsigned min never raises the running value
  assert_maxu_mono_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && elem_on && op_q == OP_MAXU) |=> (acc_q >= $past(acc_q)));
  assert_minu_mono_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && elem_on && op_q == OP_MINU) |=> (acc_q <= $past(acc_q)));

endmodule

// File: tb/vred_unit_tb.sv
module vred_unit_tb_top;

  localparam int VLEN = 128;
  localparam int VLW  = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [5:0]      funct6;
  logic [1:0]      ew;
  logic [VLW-1:0]  vl;
  logic            all_active;
  logic [VLEN-1:0] src_vec, seed_vec, mask_vec;
  logic            busy, done, err;
  logic [VLEN-1:0] dest;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vred_unit #(.VLEN(VLEN), .VLW(VLW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .funct6(funct6), .ew(ew),
    .vl(vl), .all_active(all_active), .src_vec(src_vec), .seed_vec(seed_vec),
    .mask_vec(mask_vec), .busy(busy), .done(done), .err(err), .dest(dest)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic signed [63:0] sx(input logic [63:0] v, input int w);
    logic [63:0] t;
    t = v << (64 - w);
    return $signed(t) >>> (64 - w);
  endfunction

  // behavioural reference of one whole reduction
  function automatic void ref_run(input logic [VLEN-1:0] s, sd, mk, input logic aa,
                                  input int vl_i, sw, f6,
                                  output logic [VLEN-1:0] res, output logic er,
                                  output int len);
    int w, cap;
    logic [63:0] m, a, e;
    w   = 8 << sw;
    cap = VLEN / w;
    m   = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    len = (vl_i > cap) ? cap : vl_i;
    if (f6 > 7) begin
      er = 1'b1; res = '0; len = 0;
      return;
    end
    er = 1'b0;
    a  = sd[63:0] & m;
    for (int i = 0; i < len; i++) begin
      if (!aa && !mk[i]) continue;
      e = 64'(s >> (i * w)) & m;
      case (f6)
        0: a = (a + e) & m;
        1: a = a & e;
        2: a = a | e;
        3: a = a ^ e;
        4: a = (e < a) ? e : a;
        5: a = (sx(e, w) < sx(a, w)) ? e : a;
        6: a = (e > a) ? e : a;
        default: a = (sx(e, w) > sx(a, w)) ? e : a;
      endcase
    end
    res = VLEN'(a);
  endfunction

  // cycle model
  int              m_left;
  logic            m_busy, m_done, m_err;
  logic [VLEN-1:0] m_dest, m_pend;

  always @(posedge clk or negedge rst_n) begin
    logic [VLEN-1:0] r;
    logic            e;
    int              l;
    if (!rst_n) begin
      m_left = 0; m_busy = 0; m_done = 0; m_err = 0; m_dest = '0; m_pend = '0;
    end else begin
      m_done = 0; m_err = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin m_done = 1; m_dest = m_pend; end
      end else if (start) begin
        ref_run(src_vec, seed_vec, mask_vec, all_active, int'(vl), int'(ew),
                int'(funct6), r, e, l);
        if (e || l == 0) begin
          m_done = 1; m_err = e; m_dest = r;
        end else begin
          m_left = l; m_pend = r;
        end
      end
      m_busy = (m_left > 0);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy === m_busy, "R8 busy", VLEN'(busy), VLEN'(m_busy));
      chk(done === m_done, "R8 done", VLEN'(done), VLEN'(m_done));
      chk(err  === m_err,  "R10 err", VLEN'(err),  VLEN'(m_err));
      chk(dest === m_dest, "R6 dest", dest, m_dest);
    end
  end

  task automatic issue(input logic [VLEN-1:0] s, sd, mk, input logic aa,
                       input int vl_i, sw, f6,
                       output logic [VLEN-1:0] res, output int lat, output logic er);
    @(negedge clk);
    src_vec = s; seed_vec = sd; mask_vec = mk; all_active = aa;
    vl = VLW'(vl_i); ew = 2'(sw); funct6 = 6'(f6); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    res = dest;
    er  = err;
  endtask

  task automatic hand(input string tag, input logic [VLEN-1:0] s, sd, mk,
                      input logic aa, input int vl_i, sw, f6,
                      input logic [VLEN-1:0] exp, input int exp_lat);
    logic [VLEN-1:0] r;
    int              lat;
    logic            e;
    issue(s, sd, mk, aa, vl_i, sw, f6, r, lat, e);
    chk(r === exp, tag, r, exp);
    chk(lat == exp_lat, {tag, " R8 latency"}, VLEN'(lat), VLEN'(exp_lat));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] r, rx;
    int              lat;
    logic            e, ex;
    int              l;
    rst_n = 1'b0; start = 1'b0; funct6 = '0; ew = '0; vl = '0; all_active = 1'b1;
    src_vec = '0; seed_vec = '0; mask_vec = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, err} === 3'b000, "R8 reset flags", VLEN'({busy, done, err}), '0);
    chk(dest === '0, "R8 reset dest", dest, '0);

    // R5 sum wraps at 8 bits: F0+10+10 = 110 -> 10
    hand("R5 sum wrap", 128'h1010, 128'hF0, '0, 1, 2, 0, 0, 128'h10, 2);
    // R1 signed vs unsigned ordering on 80 / 7F
    hand("R1 maxu", 128'h7F80, 128'h00, '0, 1, 2, 0, 6, 128'h80, 2);
    hand("R1 max",  128'h7F80, 128'h00, '0, 1, 2, 0, 7, 128'h7F, 2);
    hand("R1 minu", 128'h7F80, 128'h05, '0, 1, 2, 0, 4, 128'h05, 2);
    hand("R1 min",  128'h7F80, 128'h05, '0, 1, 2, 0, 5, 128'h80, 2);
    hand("R1 and",  128'h3CF0, 128'hFF, '0, 1, 2, 0, 1, 128'h30, 2);
    hand("R1 or",   128'h3CF0, 128'h01, '0, 1, 2, 0, 2, 128'hFD, 2);
    hand("R1 xor",  128'h3CF0, 128'h01, '0, 1, 2, 0, 3, 128'hCD, 2);
    // R5 16-bit elements
    hand("R5 sum16", 128'h0100_1234, 128'h0001, '0, 1, 2, 1, 0, 128'h1335, 2);
    // R2 seed upper bits ignored, R6 upper destination cleared
    hand("R2 seed low bits", 128'h02, {{15{8'hFF}}, 8'h01}, '0, 1, 1, 0, 0, 128'h03, 1);
    // R4 mask 0101 on elements 1,2,3,4 -> 1+3; all_active ignores mask
    hand("R4 masked", 128'h04030201, 128'h00, 128'h5, 0, 4, 0, 0, 128'h04, 4);
    hand("R4 all active", 128'h04030201, 128'h00, 128'h5, 1, 4, 0, 0, 128'h0A, 4);
    // R7 empty length and fully masked
    hand("R7 vl zero", 128'h04030201, 128'h5A, '0, 1, 0, 0, 0, 128'h5A, 0);
    hand("R7 all masked", 128'h04030201, 128'h5A, '0, 0, 4, 0, 0, 128'h5A, 4);
    // R3 elements past vl ignored; vl clamped to 2 at 64 bits
    hand("R3 beyond vl", 128'h640201, 128'h00, '0, 1, 2, 0, 0, 128'h03, 2);
    hand("R3 clamp", {64'd7, 64'd5}, 128'h01, '0, 1, 16, 3, 0, 128'd13, 2);
    // R10 unknown operation codes
    issue(128'h1, 128'h1, '0, 1, 3, 0, 8, r, lat, e);
    chk(r === '0, "R10 dest zero", r, '0);
    chk(e === 1'b1, "R10 err", VLEN'(e), 1);
    chk(lat == 0, "R10 latency", VLEN'(lat), 0);
    issue(128'h1, 128'h1, '0, 1, 3, 0, 32, r, lat, e);
    chk(e === 1'b1, "R10 err high code", VLEN'(e), 1);

    // R9 start while busy is ignored
    @(negedge clk);
    src_vec = {16{8'h01}}; seed_vec = '0; mask_vec = '0; all_active = 1;
    vl = 5'd16; ew = 2'd0; funct6 = 6'd0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    src_vec = {16{8'h22}}; funct6 = 6'd3; start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    chk(dest === 128'h10, "R9 ignored start", dest, 128'h10);
    repeat (3) @(negedge clk);
    chk(dest === 128'h10, "R9 dest holds", dest, 128'h10);

    // randomized operations; the cycle model checks every clock
    for (int k = 0; k < 200; k++) begin
      logic [VLEN-1:0] s, sd, mk;
      int sw, f6, vli;
      logic aa;
      s  = {$urandom, $urandom, $urandom, $urandom};
      sd = {$urandom, $urandom, $urandom, $urandom};
      mk = VLEN'($urandom);
      aa = 1'($urandom);
      sw = int'($urandom % 4);
      f6 = int'($urandom % 9);
      vli = int'($urandom % 21);
      ref_run(s, sd, mk, aa, vli, sw, f6, rx, ex, l);
      issue(s, sd, mk, aa, vli, sw, f6, r, lat, e);
      chk(r === rx, "R1 random result", r, rx);
      chk(lat == l, "R8 random latency", VLEN'(lat), VLEN'(l));
    end

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule